// File: doc/BRIEF.md
# Static Memory Byte-Lane Strobe Generator

This block converts a single internal static-memory access request into the external control pins for one bank. These pins are a shifted device address, four active-low byte-lane strobes, a common write enable, an output enable and a chip select. The bank may be 8, 16 or 32 bits wide. The device address is the byte address shifted down by the bank width and cut to 21 bits. Narrow banks sit on the upper byte lanes, and lane 3 carries the lowest-addressed byte.

A per-bank lane-mode bit sets how the lane strobes are used. When it is 0, each 8-bit device takes its write enable from a lane strobe. In that mode every strobe stays high on reads and the common write enable is never driven. When it is 1, the strobes mark the addressed bytes on both reads and writes, and the common write enable is driven on writes.

All outputs come from registers. Each access holds its pins for a fixed number of cycles, and a busy output blocks new requests until the pins have returned high. A request that is too wide for the bank, misaligned, or uses a reserved code raises a one-cycle error flag and drives nothing.

Top module: `sram_lane_strobe`

## Requirements
- R1: In reset and after reset, `mem_cs_n`, `mem_oe_n`, `mem_we_n` and all bits of `lane_strb_n` are high, `mem_addr` is 0, and `busy` and `err` are 0.
- R2: `mem_addr` equals the byte address shifted right by `bank_width` (0 = 8-bit, 1 = 16-bit, 2 = 32-bit), keeping the low 21 bits.
- R3: A 32-bit bank uses lanes 3..0, a 16-bit bank uses lanes 3..2, and an 8-bit bank uses lane 3. The byte at offset `o` within the bank word (o = address mod bank bytes) goes to lane `3-o`. Size codes are 0 = byte, 1 = halfword, 2 = word. On a write, exactly the addressed lanes of `lane_strb_n` are low.
- R4: With `lane_strb_rd` = 0, `lane_strb_n` is 4'b1111 for the whole of a read access.
- R5: With `lane_strb_rd` = 0, `mem_we_n` is never driven low.
- R6: With `lane_strb_rd` = 1, the addressed lanes are low on reads and on writes, and `mem_we_n` is low on writes only.
- R7: `mem_cs_n` is low for every access. `mem_oe_n` is low for reads only and is never low together with `mem_we_n`.
- R8: An accepted request is an error when the size exceeds the bank width, the address is not aligned to the size, or the size code is 3 or the width code is 3. An error request pulses `err` for one cycle, one cycle after acceptance, and leaves every strobe high and `busy` at 0.
- R9: A valid request seen at a clock edge with `busy` low drives its pins from the next cycle for exactly `HOLD_CYCLES` (2) cycles. The pins then return high in the same cycle that `busy` falls.
- R10: A request presented while `busy` is high is ignored. It does not change the pins of the current access, it raises no error, and it creates no further access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_write | input | 1 | 1 write, 0 read |
| bank_width | input | 2 | 0 8-bit, 1 16-bit, 2 32-bit, 3 reserved |
| lane_strb_rd | input | 1 | Lane mode: 1 strobes qualify reads too and the common write enable is used |
| mem_addr | output | 21 | Device address |
| lane_strb_n | output | 4 | Active-low byte-lane strobes |
| mem_we_n | output | 1 | Common active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | Access in progress, requests blocked |
| err | output | 1 | One-cycle error pulse |

## Verification
Two events can fall in the same cycle: the error check and busy blocking, or a new request and the release of the current access. The bench holds `req_valid` over several edges that span an access, and swaps in illegal fields while `busy` is high. It then expects exactly one access, unchanged pins in both held cycles, and no error pulse. It also holds a request across the release edge and expects the second access to start only after one idle cycle with all pins high. Each access is paired in order with a queued expectation, so any extra or missing access or error shows up as a mismatch.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    BW_8    = 2'd0,
    BW_16   = 2'd1,
    BW_32   = 2'd2,
    BW_RSVD = 2'd3
  } bank_width_e;
endpackage

// File: rtl/sram_req_check.sv
module sram_req_check
  import sram_lane_pkg::*;
(
  input  logic [1:0] size,
  input  logic [1:0] width,
  input  logic [1:0] addr_lo,
  output logic       bad
);
  logic [1:0] align_mask;
  logic       misaligned;
  logic       too_wide;
  logic       reserved;

  always_comb begin
    unique case (acc_size_e'(size))
      SZ_BYTE: align_mask = 2'b00;
      SZ_HALF: align_mask = 2'b01;
      default: align_mask = 2'b11;
    endcase
    misaligned = (addr_lo & align_mask) != 2'b00;
    too_wide   = size > width;
    reserved   = (acc_size_e'(size) == SZ_RSVD) || (bank_width_e'(width) == BW_RSVD);
    bad        = misaligned | too_wide | reserved;
  end
endmodule

// File: rtl/sram_lane_decode.sv
module sram_lane_decode #(
  parameter int LANES = 4,
  localparam int OFF_W = $clog2(LANES),
  localparam int CW    = OFF_W + 2
) (
  input  logic [1:0]       width,
  input  logic [1:0]       size,
  input  logic [OFF_W-1:0] off,
  output logic [LANES-1:0] sel
);
  logic [CW-1:0] bank_bytes;
  logic [CW-1:0] n_bytes;
  logic [CW-1:0] offset;
  logic [CW-1:0] span_end;

  always_comb begin
    bank_bytes = CW'(1) << width;
    n_bytes    = CW'(1) << size;
    offset     = CW'(off) & (bank_bytes - CW'(1));
    span_end   = offset + n_bytes;
  end

  // lane k holds byte position LANES-1-k of the bank word
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam logic [CW-1:0] POS = CW'(LANES - 1 - k);
    assign sel[k] = (POS >= offset) && (POS < span_end) && (POS < bank_bytes);
  end
endmodule

// File: rtl/sram_addr_map.sv
module sram_addr_map #(
  parameter int ADDR_W = 32,
  parameter int DEV_W  = 21,
  parameter int N_WIDTHS = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        width,
  output logic [DEV_W-1:0]  dev_addr
);
  logic [DEV_W-1:0] cand [N_WIDTHS];

  for (genvar w = 0; w < N_WIDTHS; w++) begin : g_shift
    logic [ADDR_W-1:0] shifted;
    assign shifted = addr >> w;
    assign cand[w] = shifted[DEV_W-1:0];
  end

  always_comb begin
    dev_addr = '0;
    for (int w = 0; w < N_WIDTHS; w++) begin
      if (width == 2'(w)) dev_addr = cand[w];
    end
  end
endmodule

// File: rtl/sram_hold_ctrl.sv
module sram_hold_ctrl #(
  parameter int HOLD_CYCLES = 2,
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= CNT_W'(HOLD_CYCLES);
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign busy = cnt != '0;
  assign last = cnt == CNT_W'(1);

  // R9
  hold_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(HOLD_CYCLES));

  // R10
  start_idle_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
endmodule

// File: rtl/sram_lane_strobe.sv
module sram_lane_strobe
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DEV_W       = 21,
  parameter int LANES       = 4,
  parameter int HOLD_CYCLES = 2,
  localparam int OFF_W      = $clog2(LANES),
  localparam int RUN_W      = $clog2(HOLD_CYCLES + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [1:0]        bank_width,
  input  logic              lane_strb_rd,
  output logic [DEV_W-1:0]  mem_addr,
  output logic [LANES-1:0]  lane_strb_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_cs_n,
  output logic              busy,
  output logic              err
);
  logic             bad;
  logic             accept;
  logic             start;
  logic             last;
  logic [LANES-1:0] sel;
  logic [DEV_W-1:0] dev_addr;
  logic [LANES-1:0] strb_next;
  logic             we_next;

  sram_req_check u_check (
    .size    (req_size),
    .width   (bank_width),
    .addr_lo (req_addr[1:0]),
    .bad     (bad)
  );

  sram_lane_decode #(.LANES(LANES)) u_lanes (
    .width (bank_width),
    .size  (req_size),
    .off   (req_addr[OFF_W-1:0]),
    .sel   (sel)
  );

  sram_addr_map #(.ADDR_W(ADDR_W), .DEV_W(DEV_W), .N_WIDTHS(OFF_W + 1)) u_amap (
    .addr     (req_addr),
    .width    (bank_width),
    .dev_addr (dev_addr)
  );

  sram_hold_ctrl #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .last  (last)
  );

  assign accept = req_valid && !busy;
  assign start  = accept && !bad;

  always_comb begin
    if (!req_write && !lane_strb_rd) strb_next = '1;
    else                             strb_next = ~sel;
    we_next = !(req_write && lane_strb_rd);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr    <= '0;
      lane_strb_n <= '1;
      mem_we_n    <= 1'b1;
      mem_oe_n    <= 1'b1;
      mem_cs_n    <= 1'b1;
      err         <= 1'b0;
    end else begin
      err <= accept && bad;
      if (start) begin
        mem_addr    <= dev_addr;
        lane_strb_n <= strb_next;
        mem_we_n    <= we_next;
        mem_oe_n    <= req_write;
        mem_cs_n    <= 1'b0;
      end else if (last) begin
        lane_strb_n <= '1;
        mem_we_n    <= 1'b1;
        mem_oe_n    <= 1'b1;
        mem_cs_n    <= 1'b1;
      end
    end
  end

  // Checking state: lane mode captured per access and run length of chip select.
  logic             mode_q;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      run_q  <= '0;
    end else begin
      if (start) mode_q <= lane_strb_rd;
      if (!mem_cs_n) run_q <= run_q + RUN_W'(1);
      else           run_q <= '0;
    end
  end

  // R4
  rd_strobes_high_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && !mem_oe_n && !mode_q) |-> (lane_strb_n == '1));

  // R5
  we_idle_mode0_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && !mode_q) |-> mem_we_n);

  // R3
  wr_has_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && mem_oe_n) |-> (lane_strb_n != '1));

  // R7
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));

  // R7
  idle_all_high_chk: assert property (@(posedge clk) disable iff (rst)
    mem_cs_n |-> (mem_oe_n && mem_we_n && (lane_strb_n == '1)));

  // R8
  err_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> (mem_cs_n && !busy));

  // R9
  run_len_chk: assert property (@(posedge clk) disable iff (rst)
    run_q <= RUN_W'(HOLD_CYCLES));

  // R9
  release_len_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_cs_n && (run_q != '0)) |-> (run_q == RUN_W'(HOLD_CYCLES)));

  // R10
  held_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && !$past(mem_cs_n)) |-> ($stable(lane_strb_n) && $stable(mem_addr)));
endmodule

// File: tb/tb_sram_lane_strobe.sv
module tb_sram_lane_strobe;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [1:0]  bank_width = 2'd2;
  logic        lane_strb_rd = 1'b0;
  logic [20:0] mem_addr;
  logic [3:0]  lane_strb_n;
  logic        mem_we_n, mem_oe_n, mem_cs_n, busy, err;

  always #10 clk = ~clk;

  sram_lane_strobe dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .bank_width(bank_width),
    .lane_strb_rd(lane_strb_rd), .mem_addr(mem_addr), .lane_strb_n(lane_strb_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_cs_n(mem_cs_n),
    .busy(busy), .err(err)
  );

  typedef struct {
    bit        is_err;
    bit [20:0] addr;
    bit [3:0]  strb;
    bit        we_n;
    bit        oe_n;
    string     tag;
  } item_t;

  item_t exp_q[$];
  item_t cur;
  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit prev_cs = 1;
  int run = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic item_t model(input bit [31:0] a, input bit [1:0] sz,
                                  input bit wr, input bit [1:0] bw, input bit md,
                                  input string tag);
    item_t it;
    int nb, bb, off;
    nb = 1 << sz;
    bb = 1 << bw;
    it.tag = tag;
    it.is_err = (sz == 3) || (bw == 3) || (sz > bw) || ((a % nb) != 0);
    it.addr = 21'(a >> bw);
    it.strb = 4'hF;
    if (!it.is_err && (wr || md)) begin
      off = a % bb;
      for (int i = 0; i < nb; i++) it.strb[3 - (off + i)] = 1'b0;
    end
    it.we_n = !(wr && md);
    it.oe_n = wr;
    return it;
  endfunction

  task automatic do_req(input bit [31:0] a, input bit [1:0] sz, input bit wr,
                        input bit [1:0] bw, input bit md, input string tag);
    while (busy) @(negedge clk);
    req_addr = a; req_size = sz; req_write = wr; bank_width = bw; lane_strb_rd = md;
    req_valid = 1'b1;
    exp_q.push_back(model(a, sz, wr, bw, md, tag));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: pops one expectation per access start or error pulse.
  always @(negedge clk) begin
    if (!rst) begin
      if (err) begin
        if (exp_q.size() == 0) chk(0, "R8 unexpected err", 1, 0);
        else begin
          cur = exp_q.pop_front();
          chk(cur.is_err, {cur.tag, " err pulse"}, 1, longint'(cur.is_err));
        end
        chk(mem_cs_n && !busy, "R8 no strobes on error", {mem_cs_n, busy}, 2'b10);
      end
      if (!mem_cs_n && prev_cs) begin
        if (exp_q.size() == 0) chk(0, "R10 unexpected access", 1, 0);
        else begin
          cur = exp_q.pop_front();
          chk(!cur.is_err, {cur.tag, " access instead of err"}, 0, 1);
        end
      end
      if (!mem_cs_n) begin
        chk(mem_addr == cur.addr, {cur.tag, " R2 addr"}, mem_addr, cur.addr);
        chk(lane_strb_n == cur.strb, {cur.tag, " R3 strobes"}, lane_strb_n, cur.strb);
        chk(mem_we_n == cur.we_n, {cur.tag, " R6 we_n"}, mem_we_n, cur.we_n);
        chk(mem_oe_n == cur.oe_n, {cur.tag, " R7 oe_n"}, mem_oe_n, cur.oe_n);
        run++;
      end else if (!prev_cs) begin
        chk(run == 2, "R9 hold length", run, 2);
        chk(!busy && lane_strb_n == 4'hF && mem_we_n && mem_oe_n,
            "R9 release", {busy, lane_strb_n}, 5'h0F);
        run = 0;
      end
      prev_cs = mem_cs_n;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 in reset
    chk(mem_cs_n && mem_oe_n && mem_we_n && lane_strb_n == 4'hF, "R1 strobes in reset",
        {mem_cs_n, mem_oe_n, mem_we_n, lane_strb_n}, 7'h7F);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_addr == 0, "R1 addr", mem_addr, 0);
    chk(!busy && !err, "R1 busy/err", {busy, err}, 0);
    chk(mem_cs_n && lane_strb_n == 4'hF, "R1 idle pins", {mem_cs_n, lane_strb_n}, 5'h1F);

    // 32-bit bank, lane mode 0
    for (int o = 0; o < 4; o++) do_req(32'h0000_1230 + 32'(o), 2'd0, 1, 2'd2, 0, "R3 wr byte w32");
    do_req(32'h0000_4440, 2'd1, 1, 2'd2, 0, "R3 wr half lo w32");
    do_req(32'h0000_4442, 2'd1, 1, 2'd2, 0, "R3 wr half hi w32");
    do_req(32'h00FF_FFFC, 2'd2, 1, 2'd2, 0, "R2 wr word w32");
    do_req(32'h0000_0808, 2'd2, 0, 2'd2, 0, "R4 rd word w32");
    do_req(32'h0000_0809, 2'd0, 0, 2'd2, 0, "R4 rd byte w32");
    // 32-bit bank, lane mode 1
    do_req(32'h0000_0101, 2'd0, 0, 2'd2, 1, "R6 rd byte w32");
    do_req(32'h0000_0102, 2'd1, 1, 2'd2, 1, "R6 wr half w32");
    // 16-bit bank
    do_req(32'h0000_1235, 2'd0, 1, 2'd1, 0, "R3 wr byte w16");
    do_req(32'h0000_1234, 2'd1, 1, 2'd1, 0, "R5 wr half w16");
    do_req(32'h0000_1236, 2'd1, 0, 2'd1, 0, "R4 rd half w16");
    do_req(32'h0000_1238, 2'd0, 0, 2'd1, 1, "R6 rd byte w16");
    // 8-bit bank
    do_req(32'h001F_FFFF, 2'd0, 1, 2'd0, 0, "R2 wr byte w8");
    do_req(32'h0000_0003, 2'd0, 1, 2'd0, 1, "R6 wr byte w8");
    do_req(32'h0000_0004, 2'd0, 0, 2'd0, 0, "R7 rd byte w8");
    // errors
    do_req(32'h0000_0000, 2'd1, 1, 2'd0, 0, "R8 half on w8");
    do_req(32'h0000_0000, 2'd2, 0, 2'd1, 0, "R8 word on w16");
    do_req(32'h0000_0001, 2'd1, 1, 2'd2, 0, "R8 misaligned half");
    do_req(32'h0000_0002, 2'd2, 1, 2'd2, 0, "R8 misaligned word");
    do_req(32'h0000_0000, 2'd3, 1, 2'd2, 0, "R8 reserved size");
    do_req(32'h0000_0000, 2'd0, 1, 2'd3, 0, "R8 reserved width");
    do_req(32'h0000_0010, 2'd0, 1, 2'd2, 0, "R8 good after errors");

    // R10: valid held across a whole access; illegal fields while busy
    while (busy) @(negedge clk);
    @(negedge clk);
    req_addr = 32'h0000_2002; req_size = 2'd1; req_write = 1; bank_width = 2'd2; lane_strb_rd = 0;
    req_valid = 1'b1;
    exp_q.push_back(model(32'h0000_2002, 2'd1, 1, 2'd2, 0, "R10 held valid"));
    @(negedge clk);
    req_size = 2'd3; req_addr = 32'h0000_3001;
    repeat (2) @(negedge clk);
    req_valid = 1'b0;

    // R9/R10: valid held across release edge -> second access after idle cycle
    while (busy) @(negedge clk);
    @(negedge clk);
    req_addr = 32'h0000_5000; req_size = 2'd2; req_write = 0; lane_strb_rd = 1;
    req_valid = 1'b1;
    exp_q.push_back(model(32'h0000_5000, 2'd2, 0, 2'd2, 1, "R9 back-to-back A"));
    exp_q.push_back(model(32'h0000_5000, 2'd2, 0, 2'd2, 1, "R9 back-to-back B"));
    repeat (4) @(negedge clk);
    req_valid = 1'b0;

    repeat (8) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all expectations consumed", exp_q.size(), 0);
    chk(mem_cs_n && !busy, "R9 idle at end", {mem_cs_n, busy}, 2'b10);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule